// File: doc/BRIEF.md
# Positional Stage Residue Reducer

This block takes one slice of a wide operand, a stage of `STAGE_W` bits that sits at a fixed position `STAGE_IDX` inside the wider word. Its real weight is the stage value times 2^((STAGE_IDX+1)·RES_W). The block returns a `RES_W`-bit value that is congruent to that weighted value modulo `MODULUS`. It uses no multiplier, no divider and no iteration.

The stage is cut into chunks of `CHUNK_W` bits. Each chunk addresses a constant table of residues that is built at elaboration. The table outputs are shifted by their chunk offset and added together. Any bits of the sum above `RES_W` are then folded back twice: each time, the excess bits address a second constant table, and the looked-up residue is added to the low bits.

The block is purely combinational. Several copies, one per stage position, let a wide operand be brought down to residue width in parallel. Adding the per-stage results together is left to the surrounding logic.

Top module: `stage_residue_reducer`

## Requirements
- R1: Chunk table entry j at this position holds (j·2^((STAGE_IDX+1)·RES_W)) mod MODULUS. A stage value v below 2^CHUNK_W therefore yields exactly (v·2^((STAGE_IDX+1)·RES_W)) mod MODULUS, and a zero stage yields zero.
- R2: For every stage value v, res_out mod MODULUS equals (v·2^((STAGE_IDX+1)·RES_W)) mod MODULUS.
- R3: Chunk k is stage bits [k·CHUNK_W +: CHUNK_W], and its table value is weighted by 2^(k·CHUNK_W). When the weighted sum is below 2^RES_W, res_out equals that sum unchanged.
- R4: Each fold replaces a value s by (s mod 2^RES_W) + ((floor(s/2^RES_W)·2^RES_W) mod MODULUS). res_out is the result of exactly two folds applied to the weighted sum.
- R5: After the first fold the intermediate value is below 2^RES_W + MODULUS.
- R6: The second fold never carries out of RES_W bits, so res_out is always below 2^RES_W.
- R7: Elaboration is rejected unless STAGE_W/2 ≤ CHUNK_W ≤ STAGE_W and 2 ≤ MODULUS < 2^RES_W. The boundary cases CHUNK_W = STAGE_W/2 and CHUNK_W = STAGE_W are legal and give correct results.
- R8: The output follows the input with no clock and no state, settling within the same cycle.
- R9: When CHUNK_W does not divide STAGE_W, the top chunk is zero-extended above the stage MSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| stage_in | input | STAGE_W | Stage value at position STAGE_IDX |
| res_out | output | RES_W | Residue-congruent reduced value |

## Verification
Assertions placed next to the logic check, on every evaluation, four things:
- every table output stays below the modulus;
- each fold preserves the value modulo the modulus;
- the first fold's bound holds;
- the second fold produces no carry.

Only the bench's sweeps can show the rest. These cover the exact arithmetic value after two folds, congruence with the positional weight, pass-through of small sums, zero padding of a partial top chunk, and the boundary chunk widths. The sweeps run exhaustively over six small configurations at three stage positions.

// File: rtl/posred_pkg.sv
`timescale 1ns/1ps
package posred_pkg;

  // (value * 2^shift) mod modulus, computed by repeated doubling so the
  // shift may exceed any native integer width.
  function automatic longint shifted_residue(input longint value,
                                             input int shift,
                                             input longint modulus);
    longint r;
    r = value % modulus;
    for (int s = 0; s < shift; s++) begin
      r = (r * 2) % modulus;
    end
    return r;
  endfunction

endpackage

// File: rtl/residue_rom.sv
`timescale 1ns/1ps
module residue_rom #(
  parameter int IDX_W   = 2,
  parameter int RES_W   = 4,
  parameter int SHIFT   = 4,
  parameter int MODULUS = 14
) (
  input  logic [IDX_W-1:0] idx,
  output logic [RES_W-1:0] val
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [RES_W-1:0] MOD_R = RES_W'(MODULUS);

  logic [RES_W-1:0] rom [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_entry
    assign rom[j] = RES_W'(posred_pkg::shifted_residue(longint'(j), SHIFT,
                                                       longint'(MODULUS)));
  end

  assign val = rom[idx];

  always_comb begin
    assert_entry_below_mod_R1: assert (val < MOD_R)
      else $error("table output %0d not below modulus", val);
  end
endmodule

// File: rtl/fold_stage.sv
`timescale 1ns/1ps
module fold_stage #(
  parameter int IN_W    = 7,
  parameter int RES_W   = 4,
  parameter int MODULUS = 14
) (
  input  logic [IN_W-1:0]  din,
  output logic [RES_W:0]   dout
);
  localparam int OVF_W = IN_W - RES_W;
  localparam logic [IN_W-1:0] MOD_IN = IN_W'(MODULUS);

  logic [RES_W-1:0] fold_val;

  residue_rom #(
    .IDX_W  (OVF_W),
    .RES_W  (RES_W),
    .SHIFT  (RES_W),
    .MODULUS(MODULUS)
  ) u_fold_rom (
    .idx(din[IN_W-1:RES_W]),
    .val(fold_val)
  );

  assign dout = {1'b0, din[RES_W-1:0]} + {1'b0, fold_val};

  always_comb begin
    assert_fold_keeps_residue_R4: assert ((IN_W'(dout) % MOD_IN) == (din % MOD_IN))
      else $error("fold changed residue: in %0d out %0d", din, dout);
  end
endmodule

// File: rtl/stage_residue_reducer.sv
`timescale 1ns/1ps
module stage_residue_reducer #(
  parameter int STAGE_IDX = 0,
  parameter int STAGE_W   = 4,
  parameter int CHUNK_W   = 2,
  parameter int RES_W     = 4,
  parameter int MODULUS   = 14
) (
  input  logic [STAGE_W-1:0] stage_in,
  output logic [RES_W-1:0]   res_out
);
  localparam int NCHUNK    = (STAGE_W + CHUNK_W - 1) / CHUNK_W;
  localparam int PAD_W     = NCHUNK * CHUNK_W;
  localparam int SUM_W     = RES_W + (NCHUNK - 1) * CHUNK_W + 1;
  localparam int POS_SHIFT = (STAGE_IDX + 1) * RES_W;
  localparam logic [RES_W:0] FIRST_LIMIT = (RES_W+1)'((1 << RES_W) + MODULUS);

  if ((2 * CHUNK_W < STAGE_W) || (CHUNK_W > STAGE_W) ||
      (MODULUS < 2) || (MODULUS >= (1 << RES_W))) begin : assert_cfg_legal_R7
    $error("illegal configuration: STAGE_W=%0d CHUNK_W=%0d RES_W=%0d MODULUS=%0d",
           STAGE_W, CHUNK_W, RES_W, MODULUS);
  end

  logic [PAD_W-1:0] stage_pad;
  logic [RES_W-1:0] chunk_val [NCHUNK];
  logic [SUM_W-1:0] term      [NCHUNK];
  logic [SUM_W-1:0] raw_sum;
  logic [RES_W:0]   fold_a;
  logic [RES_W:0]   fold_b;

  // Zero-extend the stage so a partial top chunk reads zeros above the MSB.
  assign stage_pad = PAD_W'(stage_in);

  for (genvar k = 0; k < NCHUNK; k++) begin : g_chunk
    residue_rom #(
      .IDX_W  (CHUNK_W),
      .RES_W  (RES_W),
      .SHIFT  (POS_SHIFT),
      .MODULUS(MODULUS)
    ) u_lut (
      .idx(stage_pad[k*CHUNK_W +: CHUNK_W]),
      .val(chunk_val[k])
    );
    assign term[k] = SUM_W'(chunk_val[k]) << (k * CHUNK_W);
  end

  always_comb begin
    raw_sum = '0;
    for (int k = 0; k < NCHUNK; k++) begin
      raw_sum = raw_sum + term[k];
    end
  end

  fold_stage #(
    .IN_W   (SUM_W),
    .RES_W  (RES_W),
    .MODULUS(MODULUS)
  ) u_fold_a (
    .din (raw_sum),
    .dout(fold_a)
  );

  fold_stage #(
    .IN_W   (RES_W + 1),
    .RES_W  (RES_W),
    .MODULUS(MODULUS)
  ) u_fold_b (
    .din (fold_a),
    .dout(fold_b)
  );

  assign res_out = fold_b[RES_W-1:0];

  always_comb begin
    assert_first_fold_bound_R5: assert (fold_a < FIRST_LIMIT)
      else $error("first fold result %0d out of bound", fold_a);
    assert_no_overflow_R6: assert (fold_b[RES_W] == 1'b0)
      else $error("second fold carried out: %0d", fold_b);
  end
endmodule

// File: tb/test_stage_residue_reducer.sv
`timescale 1ns/1ps
module test_stage_residue_reducer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 4 ns period, 250 MHz

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [3:0] s0, s1, s2, s4;
  logic [5:0] s3;
  logic [4:0] s5;
  logic [3:0] r0, r1, r2, r3, r4, r5;

  stage_residue_reducer #(.STAGE_IDX(0), .STAGE_W(4), .CHUNK_W(2), .RES_W(4), .MODULUS(14))
    i_stage_residue_reducer (.stage_in(s0), .res_out(r0));
  stage_residue_reducer #(.STAGE_IDX(1), .STAGE_W(4), .CHUNK_W(2), .RES_W(4), .MODULUS(14))
    i_stage_residue_reducer_1 (.stage_in(s1), .res_out(r1));
  stage_residue_reducer #(.STAGE_IDX(2), .STAGE_W(4), .CHUNK_W(2), .RES_W(4), .MODULUS(14))
    i_stage_residue_reducer_2 (.stage_in(s2), .res_out(r2));
  stage_residue_reducer #(.STAGE_IDX(1), .STAGE_W(6), .CHUNK_W(3), .RES_W(4), .MODULUS(11))
    i_stage_residue_reducer_3 (.stage_in(s3), .res_out(r3));
  stage_residue_reducer #(.STAGE_IDX(0), .STAGE_W(4), .CHUNK_W(4), .RES_W(4), .MODULUS(13))
    i_stage_residue_reducer_4 (.stage_in(s4), .res_out(r4));
  stage_residue_reducer #(.STAGE_IDX(0), .STAGE_W(5), .CHUNK_W(3), .RES_W(4), .MODULUS(11))
    i_stage_residue_reducer_5 (.stage_in(s5), .res_out(r5));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Weighted chunk sum, following R1 and R3.
  function automatic longint raw_model(longint v, int idx, int ww, int dd, int mm);
    longint s = 0;
    int kk = (ww + dd - 1) / dd;
    for (int k = 0; k < kk; k++) begin
      longint ch = (v >> (k * dd)) & ((longint'(1) << dd) - 1);
      s += ((ch << ((idx + 1) * 4)) % mm) << (k * dd);
    end
    return s;
  endfunction

  // One fold step, following R4 with RES_W = 4.
  function automatic longint fold_model(longint s, int mm);
    return (s & 15) + (((s >> 4) << 4) % mm);
  endfunction

  task automatic check_cfg(int c, longint v, longint act, int idx, int ww, int dd, int mm);
    longint raw = raw_model(v, idx, ww, dd, mm);
    longint exp = fold_model(fold_model(raw, mm), mm);
    longint cong = (v << ((idx + 1) * 4)) % mm;
    check(act == exp, $sformatf("R4 cfg%0d v=%0d two-fold value", c, v), act, exp);
    check((act % mm) == cong, $sformatf("R2 cfg%0d v=%0d congruence", c, v), act % mm, cong);
    check(act < 16 && exp < 16, $sformatf("R6 cfg%0d v=%0d width", c, v), act, exp);
    if (v < (longint'(1) << dd))
      check(act == cong, $sformatf("R1 cfg%0d v=%0d table entry", c, v), act, cong);
    if (raw < 16)
      check(act == raw, $sformatf("R3 cfg%0d v=%0d pass-through", c, v), act, raw);
    if (c == 0 || c == 4)
      check(act == exp, $sformatf("R7 cfg%0d v=%0d boundary chunk width", c, v), act, exp);
    if (c == 5)
      check(act == exp, $sformatf("R9 cfg%0d v=%0d padded top chunk", c, v), act, exp);
  endtask

  initial begin
    s0 = '0; s1 = '0; s2 = '0; s3 = '0; s4 = '0; s5 = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: zero stage gives zero everywhere
    check(r0 == 0 && r1 == 0 && r2 == 0, "R1 reset state cfg0-2", {r0, r1, r2}, 0);
    check(r3 == 0 && r4 == 0 && r5 == 0, "R1 reset state cfg3-5", {r3, r4, r5}, 0);

    for (int v = 0; v < 64; v++) begin
      @(posedge clk);
      s0 = 4'(v); s1 = 4'(v); s2 = 4'(v); s3 = 6'(v); s4 = 4'(v); s5 = 5'(v);
      @(negedge clk);
      if (v < 16) begin
        check_cfg(0, v, r0, 0, 4, 2, 14);
        check_cfg(1, v, r1, 1, 4, 2, 14);
        check_cfg(2, v, r2, 2, 4, 2, 14);
        check_cfg(4, v, r4, 0, 4, 4, 13);
      end
      if (v < 32) check_cfg(5, v, r5, 0, 5, 3, 11);
      check_cfg(3, v, r3, 1, 6, 3, 11);
    end

    // R8: output follows input between clock edges with no clock involved
    @(posedge clk);
    #0.5 s0 = 4'd1;
    #0.5 check(r0 == 4'd2, "R8 same-cycle response", r0, 2);
    #0.5 s0 = 4'd15;
    #0.2 check(r0 == 4'(fold_model(fold_model(raw_model(15, 0, 4, 2, 14), 14), 14)),
               "R8 same-cycle second change", r0,
               fold_model(fold_model(raw_model(15, 0, 4, 2, 14), 14), 14));

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL R8 watchdog: actual %0d cycles expected completion", 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule